// File: doc/BRIEF.md
# Frame Checksum Generator and Checker

This block keeps a running 8-bit checksum over a byte stream that is organised as frames of 256 timeslots. Each byte arrives with its timeslot index and a valid strobe. Every slot except slot 0 is added into an accumulator. The carry out of each addition is folded into the next addition, so the result is an end-around-carry sum. Slot 0 carries the frame alignment code and is never summed. On the slot 0 beat, the block stores the finished sum of the frame that just closed and restarts the accumulator from zero.

On the transmit path, the stored value is the byte placed into slot 16 of the next frame. On the receive path, the same block takes the byte that arrives in slot 16 and compares it with the stored value. Any difference produces a one-cycle mismatch pulse and increments a saturating 16-bit error counter. Two conditions suppress the comparison: the receiver being out of sync, and the first frame after reset or after a sync loss. In both cases no complete frame has been summed yet.

Top module: `frame_cksum`

## Requirements
- R1: While reset is asserted and after its release, `tx_sum_o`, `mismatch_o` and `err_cnt_o` are all zero.
- R2: Each valid beat on a slot other than 0 updates the accumulator: the new sum is acc + data + carry, kept to 8 bits, and the carry out of that addition is held for the next beat. A valid slot 0 beat copies the accumulator into `tx_sum_o` one cycle later. Any carry still pending at that point is discarded.
- R3: The byte carried in slot 0 never enters the sum. The accumulator and carry restart at zero after each slot 0 beat.
- R4: A beat with `valid_i` low changes neither the sum nor the comparison.
- R5: A valid slot 16 beat that occurs while armed and in sync, with `data_i` different from `tx_sum_o`, raises `mismatch_o` for exactly the next cycle. A matching byte raises no pulse.
- R6: `err_cnt_o` rises by one in the same cycle as each mismatch pulse and changes at no other time.
- R7: `err_cnt_o` saturates at all ones (16'hFFFF by default) and holds there.
- R8: Comparison is armed only after two consecutive valid slot 0 beats with `in_sync_i` high throughout. Any cycle with `in_sync_i` low disarms it, and while `in_sync_i` is low no mismatch is reported.
- R9: `tx_sum_o` changes only in the cycle following a valid slot 0 beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Beat qualifier for slot_i/data_i |
| slot_i | input | 8 | Timeslot index of the beat, 0..255 |
| data_i | input | 8 | Byte carried in the timeslot |
| in_sync_i | input | 1 | Receiver frame lock indication |
| tx_sum_o | output | 8 | Checksum latched at the last slot 0 |
| mismatch_o | output | 1 | One-cycle pulse on slot 16 checksum mismatch |
| err_cnt_o | output | 16 | Saturating mismatch count |

## Verification
The assertions assume that `valid_i`, `slot_i`, `data_i` and `in_sync_i` are known after reset and change only between clock edges. They do not assume that frames are complete or that slots arrive in order. For that reason the stimulus drives inputs on the falling edge and mixes sparse, out-of-order and repeated slot indices. Sync drops can occur at any point in a frame. A second instance with a 3-bit counter reaches saturation within the run.

// File: rtl/cks_pkg.sv
package cks_pkg;
  typedef struct packed {
    logic       valid;
    logic [7:0] slot;
    logic [7:0] data;
  } beat_t;
endpackage

// File: rtl/cks_accum.sv
module cks_accum #(
  parameter int DATA_W     = 8,
  parameter int SLOT_W     = 8,
  parameter int ALIGN_SLOT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] sum_o
);
  localparam logic [SLOT_W-1:0] AlignIdx = SLOT_W'(ALIGN_SLOT);

  logic [DATA_W-1:0] acc_q, sum_q;
  logic              carry_q;
  logic [DATA_W:0]   add_w;

  assign add_w = {1'b0, acc_q} + {1'b0, data_i} + {{DATA_W{1'b0}}, carry_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
      sum_q   <= '0;
    end else if (valid_i) begin
      if (slot_i == AlignIdx) begin
        sum_q   <= acc_q;  // pending carry dropped
        acc_q   <= '0;
        carry_q <= 1'b0;
      end else begin
        acc_q   <= add_w[DATA_W-1:0];
        carry_q <= add_w[DATA_W];
      end
    end
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/cks_compare.sv
module cks_compare #(
  parameter int DATA_W     = 8,
  parameter int SLOT_W     = 8,
  parameter int ALIGN_SLOT = 0,
  parameter int CHECK_SLOT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              in_sync_i,
  input  logic [DATA_W-1:0] sum_i,
  output logic              mismatch_o
);
  localparam logic [SLOT_W-1:0] AlignIdx = SLOT_W'(ALIGN_SLOT);
  localparam logic [SLOT_W-1:0] CheckIdx = SLOT_W'(CHECK_SLOT);

  logic frame_open_q, armed_q, mis_q;
  logic hit_w;

  assign hit_w = valid_i && in_sync_i && armed_q && (slot_i == CheckIdx)
                 && (data_i != sum_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_open_q <= 1'b0;
      armed_q      <= 1'b0;
      mis_q        <= 1'b0;
    end else begin
      mis_q <= hit_w;
      if (!in_sync_i) begin
        frame_open_q <= 1'b0;
        armed_q      <= 1'b0;
      end else if (valid_i && slot_i == AlignIdx) begin
        armed_q      <= frame_open_q;
        frame_open_q <= 1'b1;
      end
    end
  end

  assign mismatch_o = mis_q;
endmodule

// File: rtl/cks_err_cnt.sv
module cks_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (inc_i && cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/frame_cksum.sv
module frame_cksum #(
  parameter int DATA_W     = 8,
  parameter int SLOT_W     = 8,
  parameter int CNT_W      = 16,
  parameter int ALIGN_SLOT = 0,
  parameter int CHECK_SLOT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              in_sync_i,
  output logic [DATA_W-1:0] tx_sum_o,
  output logic              mismatch_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  logic [DATA_W-1:0] sum_w;
  logic              mis_w;
  logic              cnt_inc_w;

  cks_accum #(
    .DATA_W(DATA_W), .SLOT_W(SLOT_W), .ALIGN_SLOT(ALIGN_SLOT)
  ) u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .slot_i(slot_i), .data_i(data_i), .sum_o(sum_w)
  );

  cks_compare #(
    .DATA_W(DATA_W), .SLOT_W(SLOT_W),
    .ALIGN_SLOT(ALIGN_SLOT), .CHECK_SLOT(CHECK_SLOT)
  ) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .slot_i(slot_i), .data_i(data_i), .in_sync_i(in_sync_i),
    .sum_i(sum_w), .mismatch_o(mis_w)
  );

  // counter steps with the registered pulse's source, so both land together
  assign cnt_inc_w = valid_i && in_sync_i && (slot_i == SLOT_W'(CHECK_SLOT))
                     && u_cmp.armed_q && (data_i != sum_w);

  cks_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(cnt_inc_w), .cnt_o(err_cnt_o)
  );

  assign tx_sum_o   = sum_w;
  assign mismatch_o = mis_w;
endmodule

// File: rtl/frame_cksum_chk.sv
module frame_cksum_chk #(
  parameter int DATA_W     = 8,
  parameter int SLOT_W     = 8,
  parameter int CNT_W      = 16,
  parameter int ALIGN_SLOT = 0,
  parameter int CHECK_SLOT = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [SLOT_W-1:0] slot_i,
  input logic [DATA_W-1:0] data_i,
  input logic              in_sync_i,
  input logic [DATA_W-1:0] tx_sum_o,
  input logic              mismatch_o,
  input logic [CNT_W-1:0]  err_cnt_o
);
  always @(posedge clk_i)
    if (!rst_ni)
      assert_reset_R1: assert (err_cnt_o == '0 && !mismatch_o && tx_sum_o == '0);

  assert_pulse_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |-> $past(valid_i && in_sync_i && slot_i == SLOT_W'(CHECK_SLOT)));

  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_cnt_o) |-> (mismatch_o && err_cnt_o == $past(err_cnt_o) + 1'b1));

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o == {CNT_W{1'b1}}) |=> (err_cnt_o == {CNT_W{1'b1}}));

  assert_nosync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_sync_i |=> !mismatch_o);

  assert_sum_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_sum_o) |-> $past(valid_i && slot_i == SLOT_W'(ALIGN_SLOT)));
endmodule

bind frame_cksum frame_cksum_chk #(
  .DATA_W(DATA_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W),
  .ALIGN_SLOT(ALIGN_SLOT), .CHECK_SLOT(CHECK_SLOT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .slot_i(slot_i),
  .data_i(data_i), .in_sync_i(in_sync_i), .tx_sum_o(tx_sum_o),
  .mismatch_o(mismatch_o), .err_cnt_o(err_cnt_o)
);

// File: tb/sim_frame_cksum.sv
module sim_frame_cksum;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  slot_i = '0;
  logic [7:0]  data_i = '0;
  logic        in_sync_i = 1'b0;
  logic [7:0]  tx_sum_o, tx_sum_s;
  logic        mismatch_o, mismatch_s;
  logic [15:0] err_cnt_o;
  logic [2:0]  err_cnt_s;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  frame_cksum u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .slot_i(slot_i),
    .data_i(data_i), .in_sync_i(in_sync_i), .tx_sum_o(tx_sum_o),
    .mismatch_o(mismatch_o), .err_cnt_o(err_cnt_o)
  );

  frame_cksum #(.CNT_W(3)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .slot_i(slot_i),
    .data_i(data_i), .in_sync_i(in_sync_i), .tx_sum_o(tx_sum_s),
    .mismatch_o(mismatch_s), .err_cnt_o(err_cnt_s)
  );

  // behavioural reference
  int m_acc = 0, m_carry = 0, m_sum = 0, m_cnt = 0, m_cnt_s = 0;
  bit m_open = 0, m_armed = 0, m_mis = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_acc = 0; m_carry = 0; m_sum = 0; m_cnt = 0; m_cnt_s = 0;
      m_open = 0; m_armed = 0; m_mis = 0;
    end else begin
      bit hit;
      hit = valid_i && in_sync_i && m_armed && slot_i == 16 && int'(data_i) != m_sum;
      m_mis = hit;
      if (hit) begin
        if (m_cnt < 65535) m_cnt++;
        if (m_cnt_s < 7)   m_cnt_s++;
      end
      if (!in_sync_i) begin
        m_open = 0; m_armed = 0;
      end else if (valid_i && slot_i == 0) begin
        m_armed = m_open; m_open = 1;
      end
      if (valid_i) begin
        if (slot_i == 0) begin
          m_sum = m_acc; m_acc = 0; m_carry = 0;
        end else begin
          int t;
          t = m_acc + int'(data_i) + m_carry;
          m_acc = t % 256; m_carry = t / 256;
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_model();
    check("R2 sum", int'(tx_sum_o), m_sum);
    check("R5 mismatch", int'(mismatch_o), int'(m_mis));
    check("R6 count", int'(err_cnt_o), m_cnt);
    check("R7 sat count", int'(err_cnt_s), m_cnt_s);
  endtask

  task automatic beat(input bit v, input int s, input int d);
    valid_i = v; slot_i = 8'(s); data_i = 8'(d);
    @(negedge clk);
    compare_model();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sum", int'(tx_sum_o), 0);
    check("R1 mismatch", int'(mismatch_o), 0);
    check("R1 count", int'(err_cnt_o), 0);
    rst_ni = 1'b1;
    in_sync_i = 1'b1;
    @(negedge clk);
    check("R1 after release", int'(err_cnt_o), 0);

    // frame A: opens arming; slot16 wrong but not armed (R8)
    beat(1, 0, 8'h55);
    beat(1, 1, 8'hFF);
    beat(1, 2, 8'h02);
    beat(1, 16, 8'h00);
    check("R8 first frame no pulse", int'(mismatch_o), 0);
    beat(1, 3, 8'h00);
    beat(1, 0, 8'hAA);
    check("R2 R3 end-around sum", int'(tx_sum_o), 8'h02);

    // frame B: matching checksum, invalid beat ignored, carry discarded
    beat(0, 1, 8'h77);
    check("R9 sum held", int'(tx_sum_o), 8'h02);
    beat(1, 16, 8'h02);
    check("R5 match no pulse", int'(mismatch_o), 0);
    beat(1, 1, 8'h80);
    beat(1, 2, 8'h7E);
    beat(1, 0, 8'h00);
    check("R2 R4 carry discarded", int'(tx_sum_o), 8'h00);

    // frame C: mismatch
    beat(1, 16, 8'h01);
    check("R5 pulse", int'(mismatch_o), 1);
    check("R6 count step", int'(err_cnt_o), 1);
    beat(1, 5, 8'h00);
    check("R5 pulse one cycle", int'(mismatch_o), 0);
    check("R6 count stable", int'(err_cnt_o), 1);

    // sync loss then frame D: suppressed
    in_sync_i = 1'b0;
    beat(1, 7, 8'h00);
    in_sync_i = 1'b1;
    beat(1, 0, 8'h00);
    beat(1, 16, 8'h33);
    check("R8 after sync loss", int'(mismatch_o), 0);
    beat(1, 0, 8'h00);
    beat(1, 16, 8'h99);
    check("R8 rearmed", int'(mismatch_o), 1);

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      int r, s;
      r = $urandom_range(0, 99);
      s = (r < 6) ? 0 : (r < 20) ? 16 : $urandom_range(1, 255);
      in_sync_i = ($urandom_range(0, 199) != 0);
      beat($urandom_range(0, 9) != 0, s, $urandom_range(0, 255));
    end
    check("R7 small counter saturated", int'(err_cnt_s), 7);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule